// File: doc/BRIEF.md
# UART host register file

This block is the byte-wide register window a host uses to control a 16550-style UART. It turns a 3-bit offset and single-cycle read and write strobes into accesses on these registers: line control, line status, interrupt enable, interrupt identification, FIFO control, modem control, modem status and the 16-bit baud divisor. When the divisor-access bit in line control is set, offsets 0 and 1 reach the two divisor bytes instead of the data and interrupt-enable registers.

The serial engine sits beside the block. The block gathers live status from the receiver and transmitter, keeps the receive error flags sticky until the host reads line status, and ranks the pending interrupt causes into one identification code. It also drives the engine's controls: divisor, frame format, break request, FIFO clear pulses, and one-cycle push and pop strobes for the data register. Read data is combinational in the cycle of the strobe. Every side effect appears on a registered output one cycle after the strobe.

Top module: `uart_regfile`

## Requirements
- R1: After reset, reading gives line control 0x03, modem control 0x00, interrupt enable 0x00, identification 0xC1, line status 0x60, modem status 0x00, and both divisor bytes 0x00. The status values hold with `thr_empty_i` and `tx_idle_i` high and every other status input low.
- R2: With line control bit 7 set, a write to offset 0 stores the divisor low byte and a write to offset 1 stores the high byte. Reads at those offsets return the stored bytes, `divisor_o` carries the 16-bit value, and a divisor write produces no transmit push.
- R3: With line control bit 7 clear, a write to offset 0 raises `tx_push_o` for exactly one cycle, in the cycle after the write, with the written byte on `tx_data_o`, and leaves the divisor unchanged. A write to offset 1 stores the low 4 bits into interrupt enable; the upper bits read as 0.
- R4: With line control bit 7 clear, a read at offset 0 returns `rx_data_i` and raises `rx_pop_o` for one cycle, in the cycle after the read. With bit 7 set, the same read raises no pop.
- R5: Line control (offset 3) reads back the last byte written. Its fields drive these outputs: bits 1:0 word length, bit 2 extra stop, bit 3 parity enable, bit 4 even parity, bit 5 stick parity, bit 6 break.
- R6: Line status (offset 5) carries these bits: 0 data ready, 1 overrun, 2 parity error, 3 framing error, 4 break, 5 holding register empty, 6 transmitter idle.
- R7: Line status bit 7 is 1 exactly when any of bits 1 to 4 is 1.
- R8: Line status bits 1 to 4 stay set after their input drops and clear on a line status read. A bit whose input is still high at that read stays set.
- R9: A write to offset 2 with data bit 1 set raises `rx_fifo_clr_o`, and with data bit 2 set raises `tx_fifo_clr_o`, each for one cycle in the cycle after the write. Nothing is stored; offset 2 reads return the identification code.
- R10: Identification reads 0xC6 for a line error when enable bit 2 is set. Otherwise it reads 0xC4 for data ready when enable bit 0 is set, then 0xC2 for holding register empty when enable bit 1 is set, then 0xC0 for `msr_i[3:0]` nonzero when enable bit 3 is set, else 0xC1. `irq_o` is high when the code is not 0xC1.
- R11: Modem control (offset 4) stores the low 5 bits, reads the upper bits as 0 and drives `mcr_o`. Modem status (offset 6) reads `msr_i`.
- R12: Offset 7 reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| rx_data_i | input | 8 | Byte at the receive head |
| rx_ready_i | input | 1 | Receive data available |
| rx_overrun_i | input | 1 | Receiver overrun |
| rx_parity_err_i | input | 1 | Receiver parity error |
| rx_frame_err_i | input | 1 | Receiver framing error |
| rx_break_i | input | 1 | Receiver break detected |
| thr_empty_i | input | 1 | Transmit holding register empty |
| tx_idle_i | input | 1 | Transmitter fully idle |
| msr_i | input | 8 | Modem status byte |
| tx_push_o | output | 1 | Transmit push strobe |
| tx_data_o | output | 8 | Byte to transmit |
| rx_pop_o | output | 1 | Receive pop strobe |
| rx_fifo_clr_o | output | 1 | Receive FIFO clear pulse |
| tx_fifo_clr_o | output | 1 | Transmit FIFO clear pulse |
| divisor_o | output | 16 | Baud divisor |
| word_len_o | output | 2 | Word length code |
| stop_ext_o | output | 1 | Extra stop bit select |
| parity_en_o | output | 1 | Parity enable |
| parity_even_o | output | 1 | Even parity select |
| parity_stick_o | output | 1 | Stick parity |
| break_o | output | 1 | Break request |
| mcr_o | output | 5 | Modem control bits |
| irq_o | output | 1 | Interrupt pending |

## Verification
A wrong divisor-access decode shows at once. A data write would pulse `tx_push_o` in the next cycle or move `divisor_o`, and a read would pop in the next cycle or return the wrong byte in the same cycle. A sticky flag that is lost or never clears shows on the first line status read after the receiver input drops. It also shows through the line-error identification code, which is visible with no clearing read at all. Priority faults show as a wrong identification code in the same cycle when several causes are active together.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned IEN_W  = 4;
  localparam int unsigned ERR_N  = 4;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_IID   = 3'd2,
    OFS_LCTL  = 3'd3,
    OFS_MCTL  = 3'd4,
    OFS_LSTAT = 3'd5,
    OFS_MSTAT = 3'd6,
    OFS_SPARE = 3'd7
  } reg_ofs_e;

  // line control bit positions
  localparam int unsigned LC_DLAB  = 7;
  localparam int unsigned LC_BRK   = 6;
  localparam int unsigned LC_STICK = 5;
  localparam int unsigned LC_EVEN  = 4;
  localparam int unsigned LC_PEN   = 3;
  localparam int unsigned LC_STOP  = 2;

  // interrupt enable bit positions
  localparam int unsigned IE_RXD   = 0;
  localparam int unsigned IE_THRE  = 1;
  localparam int unsigned IE_LINE  = 2;
  localparam int unsigned IE_MODEM = 3;

  localparam logic [BYTE_W-1:0] IID_NONE  = 8'hC1;
  localparam logic [BYTE_W-1:0] IID_LINE  = 8'hC6;
  localparam logic [BYTE_W-1:0] IID_RXD   = 8'hC4;
  localparam logic [BYTE_W-1:0] IID_THRE  = 8'hC2;
  localparam logic [BYTE_W-1:0] IID_MODEM = 8'hC0;

  typedef struct packed {
    logic data_wr;
    logic data_rd;
    logic ien_wr;
    logic div_lo_wr;
    logic div_hi_wr;
    logic fifo_wr;
    logic lctl_wr;
    logic mctl_wr;
    logic lstat_rd;
  } reg_acc_t;
endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
  import uart_regs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              dlab_i,
  output reg_acc_t          acc_o
);
  always_comb begin
    acc_o = '0;
    case (reg_ofs_e'(addr_i))
      OFS_DATA: begin
        acc_o.data_wr   = wr_i & ~dlab_i;
        acc_o.data_rd   = rd_i & ~dlab_i;
        acc_o.div_lo_wr = wr_i & dlab_i;
      end
      OFS_IEN: begin
        acc_o.ien_wr    = wr_i & ~dlab_i;
        acc_o.div_hi_wr = wr_i & dlab_i;
      end
      OFS_IID:   acc_o.fifo_wr  = wr_i;
      OFS_LCTL:  acc_o.lctl_wr  = wr_i;
      OFS_MCTL:  acc_o.mctl_wr  = wr_i;
      OFS_LSTAT: acc_o.lstat_rd = rd_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/uart_lsr_track.sv
module uart_lsr_track #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] live_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] held_q;

  for (genvar b = 0; b < N; b++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    held_q[b] <= 1'b0;
      else if (clr_i) held_q[b] <= live_i[b];  // survives the read while still active
      else            held_q[b] <= held_q[b] | live_i[b];
    end
    assign flags_o[b] = held_q[b] | live_i[b];
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_regs_pkg::*;
(
  input  logic [IEN_W-1:0]  ien_i,
  input  logic              line_err_i,
  input  logic              rx_ready_i,
  input  logic              thr_empty_i,
  input  logic              modem_chg_i,
  output logic [BYTE_W-1:0] iid_o
);
  always_comb begin
    if (ien_i[IE_LINE] && line_err_i)        iid_o = IID_LINE;
    else if (ien_i[IE_RXD] && rx_ready_i)    iid_o = IID_RXD;
    else if (ien_i[IE_THRE] && thr_empty_i)  iid_o = IID_THRE;
    else if (ien_i[IE_MODEM] && modem_chg_i) iid_o = IID_MODEM;
    else                                     iid_o = IID_NONE;
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regs_pkg::*;
#(
  parameter int unsigned       MCR_W   = 5,
  parameter logic [BYTE_W-1:0] LCR_RST = 8'h03
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [BYTE_W-1:0]   rdata_o,
  input  logic [BYTE_W-1:0]   rx_data_i,
  input  logic                rx_ready_i,
  input  logic                rx_overrun_i,
  input  logic                rx_parity_err_i,
  input  logic                rx_frame_err_i,
  input  logic                rx_break_i,
  input  logic                thr_empty_i,
  input  logic                tx_idle_i,
  input  logic [BYTE_W-1:0]   msr_i,
  output logic                tx_push_o,
  output logic [BYTE_W-1:0]   tx_data_o,
  output logic                rx_pop_o,
  output logic                rx_fifo_clr_o,
  output logic                tx_fifo_clr_o,
  output logic [2*BYTE_W-1:0] divisor_o,
  output logic [1:0]          word_len_o,
  output logic                stop_ext_o,
  output logic                parity_en_o,
  output logic                parity_even_o,
  output logic                parity_stick_o,
  output logic                break_o,
  output logic [MCR_W-1:0]    mcr_o,
  output logic                irq_o
);
  localparam int unsigned DIV_W = 2 * BYTE_W;

  reg_acc_t            acc;
  logic [BYTE_W-1:0]   lcr_q;
  logic [IEN_W-1:0]    ien_q;
  logic [MCR_W-1:0]    mcr_q;
  logic [DIV_W-1:0]    div_q;
  logic [ERR_N-1:0]    err_live, err_flags;
  logic [BYTE_W-1:0]   lsr, iid;
  logic                push_q, pop_q, rx_clr_q, tx_clr_q;
  logic [BYTE_W-1:0]   txd_q;

  uart_reg_decode i_dec (
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .rd_i   (rd_i),
    .dlab_i (lcr_q[LC_DLAB]),
    .acc_o  (acc)
  );

  // order matches line status bits 1..4
  assign err_live = {rx_break_i, rx_frame_err_i, rx_parity_err_i, rx_overrun_i};

  uart_lsr_track #(.N(ERR_N)) i_lsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .live_i  (err_live),
    .clr_i   (acc.lstat_rd),
    .flags_o (err_flags)
  );

  assign lsr = {|err_flags, tx_idle_i, thr_empty_i, err_flags, rx_ready_i};

  uart_irq_prio i_irq (
    .ien_i       (ien_q),
    .line_err_i  (|err_flags),
    .rx_ready_i  (rx_ready_i),
    .thr_empty_i (thr_empty_i),
    .modem_chg_i (|msr_i[3:0]),
    .iid_o       (iid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q <= LCR_RST;
      ien_q <= '0;
      mcr_q <= '0;
      div_q <= '0;
    end else begin
      if (acc.lctl_wr)   lcr_q <= wdata_i;
      if (acc.ien_wr)    ien_q <= wdata_i[IEN_W-1:0];
      if (acc.mctl_wr)   mcr_q <= wdata_i[MCR_W-1:0];
      if (acc.div_lo_wr) div_q[BYTE_W-1:0] <= wdata_i;
      if (acc.div_hi_wr) div_q[DIV_W-1:BYTE_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_q   <= 1'b0;
      pop_q    <= 1'b0;
      rx_clr_q <= 1'b0;
      tx_clr_q <= 1'b0;
      txd_q    <= '0;
    end else begin
      push_q   <= acc.data_wr;
      pop_q    <= acc.data_rd;
      rx_clr_q <= acc.fifo_wr & wdata_i[1];
      tx_clr_q <= acc.fifo_wr & wdata_i[2];
      if (acc.data_wr) txd_q <= wdata_i;
    end
  end

  always_comb begin
    case (reg_ofs_e'(addr_i))
      OFS_DATA:  rdata_o = lcr_q[LC_DLAB] ? div_q[BYTE_W-1:0] : rx_data_i;
      OFS_IEN:   rdata_o = lcr_q[LC_DLAB] ? div_q[DIV_W-1:BYTE_W] : BYTE_W'(ien_q);
      OFS_IID:   rdata_o = iid;
      OFS_LCTL:  rdata_o = lcr_q;
      OFS_MCTL:  rdata_o = BYTE_W'(mcr_q);
      OFS_LSTAT: rdata_o = lsr;
      OFS_MSTAT: rdata_o = msr_i;
      default:   rdata_o = '0;
    endcase
  end

  assign tx_push_o      = push_q;
  assign tx_data_o      = txd_q;
  assign rx_pop_o       = pop_q;
  assign rx_fifo_clr_o  = rx_clr_q;
  assign tx_fifo_clr_o  = tx_clr_q;
  assign divisor_o      = div_q;
  assign word_len_o     = lcr_q[1:0];
  assign stop_ext_o     = lcr_q[LC_STOP];
  assign parity_en_o    = lcr_q[LC_PEN];
  assign parity_even_o  = lcr_q[LC_EVEN];
  assign parity_stick_o = lcr_q[LC_STICK];
  assign break_o        = lcr_q[LC_BRK];
  assign mcr_o          = mcr_q;
  assign irq_o          = (iid != IID_NONE);
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  addr_i,
  input logic [7:0]  wdata_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [7:0]  rdata_o,
  input logic        tx_push_o,
  input logic        rx_pop_o,
  input logic        rx_fifo_clr_o,
  input logic        tx_fifo_clr_o,
  input logic [15:0] divisor_o,
  input logic [1:0]  word_len_o,
  input logic        break_o
);
  // R3
  push_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> ($past(wr_i && addr_i == 3'd0) && $stable(divisor_o)));

  // R4
  pop_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> $past(rd_i && addr_i == 3'd0));

  // R9
  rx_clr_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_fifo_clr_o |-> $past(wr_i && addr_i == 3'd2 && wdata_i[1]));

  // R9
  tx_clr_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fifo_clr_o |-> $past(wr_i && addr_i == 3'd2 && wdata_i[2]));

  // R7
  err_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 3'd5) |-> (rdata_o[7] == (|rdata_o[4:1])));

  // R5
  lctl_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd3) |-> (rdata_o[6] == break_o && rdata_o[1:0] == word_len_o));
endmodule

bind uart_regfile uart_regfile_chk i_regfile_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .wr_i          (wr_i),
  .rd_i          (rd_i),
  .rdata_o       (rdata_o),
  .tx_push_o     (tx_push_o),
  .rx_pop_o      (rx_pop_o),
  .rx_fifo_clr_o (rx_fifo_clr_o),
  .tx_fifo_clr_o (tx_fifo_clr_o),
  .divisor_o     (divisor_o),
  .word_len_o    (word_len_o),
  .break_o       (break_o)
);

// File: tb/test_uart_regfile.sv
module test_uart_regfile;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic [7:0] rx_data_i = '0;
  logic rx_ready_i = 0, rx_overrun_i = 0, rx_parity_err_i = 0, rx_frame_err_i = 0, rx_break_i = 0;
  logic thr_empty_i = 1, tx_idle_i = 1;
  logic [7:0] msr_i = '0;
  logic tx_push_o, rx_pop_o, rx_fifo_clr_o, tx_fifo_clr_o;
  logic [7:0] tx_data_o;
  logic [15:0] divisor_o;
  logic [1:0] word_len_o;
  logic stop_ext_o, parity_en_o, parity_even_o, parity_stick_o, break_o, irq_o;
  logic [4:0] mcr_o;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  uart_regfile i_uart_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i), .wr_i(wr_i), .rd_i(rd_i),
    .rdata_o(rdata_o), .rx_data_i(rx_data_i), .rx_ready_i(rx_ready_i), .rx_overrun_i(rx_overrun_i),
    .rx_parity_err_i(rx_parity_err_i), .rx_frame_err_i(rx_frame_err_i), .rx_break_i(rx_break_i),
    .thr_empty_i(thr_empty_i), .tx_idle_i(tx_idle_i), .msr_i(msr_i), .tx_push_o(tx_push_o),
    .tx_data_o(tx_data_o), .rx_pop_o(rx_pop_o), .rx_fifo_clr_o(rx_fifo_clr_o),
    .tx_fifo_clr_o(tx_fifo_clr_o), .divisor_o(divisor_o), .word_len_o(word_len_o),
    .stop_ext_o(stop_ext_o), .parity_en_o(parity_en_o), .parity_even_o(parity_even_o),
    .parity_stick_o(parity_stick_o), .break_o(break_o), .mcr_o(mcr_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr_i = a; rd_i = 1'b1;
    sb.push_back('{exp: e, tag: tag});
    @(negedge clk);
    rd_i = 1'b0;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // monitor: compares read data in the strobe cycle, before the capturing edge
  always @(negedge clk) begin
    #2;
    if (rd_i) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL scoreboard empty actual=%h expected=none", rdata_o);
      end else begin
        exp_t it;
        it = sb.pop_front();
        check(it.tag, {24'd0, rdata_o}, {24'd0, it.exp});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [15:0] last_div;
    last_div = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(3'd3, 8'h03, "R1 lctl");
    rd(3'd4, 8'h00, "R1 mctl");
    rd(3'd5, 8'h60, "R1 lstat");
    rd(3'd6, 8'h00, "R1 mstat");
    rd(3'd2, 8'hC1, "R1 iid");
    rd(3'd1, 8'h00, "R1 ien");
    check("R1 divisor", divisor_o, 0);
    check("R1 irq", irq_o, 0);
    wr(3'd3, 8'h80);
    rd(3'd0, 8'h00, "R1 div lo");
    rd(3'd1, 8'h00, "R1 div hi");

    // R5 line control fields
    wr(3'd3, 8'h7F);
    check("R5 fields 7F", {word_len_o, stop_ext_o, parity_en_o, parity_even_o, parity_stick_o, break_o}, 7'b11_11111);
    rd(3'd3, 8'h7F, "R5 readback 7F");
    wr(3'd3, 8'h95);
    check("R5 fields 95", {word_len_o, stop_ext_o, parity_en_o, parity_even_o, parity_stick_o, break_o}, 7'b01_10100);
    rd(3'd3, 8'h95, "R5 readback 95");

    // R2 divisor overlay, walking pattern
    wr(3'd3, 8'h80);
    for (int i = 0; i < 16; i++) begin
      logic [15:0] t;
      t = 16'hDEAD << i;
      wr(3'd1, t[15:8]);
      wr(3'd0, t[7:0]);
      check("R2 no push on divisor write", tx_push_o, 0);
      rd(3'd0, t[7:0], "R2 div lo");
      rd(3'd1, t[15:8], "R2 div hi");
      check("R2 divisor_o", divisor_o, t);
      last_div = t;
    end

    // R3 data write and interrupt enable
    wr(3'd3, 8'h03);
    wr(3'd0, 8'h5A);
    check("R3 push", tx_push_o, 1);
    check("R3 tx data", tx_data_o, 8'h5A);
    idle(1);
    check("R3 push single", tx_push_o, 0);
    check("R3 divisor kept", divisor_o, last_div);
    rd(3'd1, 8'h00, "R3 ien untouched by divisor writes");
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h0F, "R3 ien width");
    wr(3'd1, 8'h00);

    // R4 data read
    rx_data_i = 8'hA7;
    rd(3'd0, 8'hA7, "R4 rx data");
    check("R4 pop", rx_pop_o, 1);
    idle(1);
    check("R4 pop single", rx_pop_o, 0);
    wr(3'd3, 8'h83);
    rd(3'd0, last_div[7:0], "R4 dlab read");
    check("R4 no pop under dlab", rx_pop_o, 0);
    wr(3'd3, 8'h03);

    // R6 status layout
    rx_ready_i = 1; rd(3'd5, 8'h61, "R6 data ready"); rx_ready_i = 0;
    thr_empty_i = 0; tx_idle_i = 0; rd(3'd5, 8'h00, "R6 tx busy");
    thr_empty_i = 1; rd(3'd5, 8'h20, "R6 thr empty only");
    tx_idle_i = 1;

    // R7 R8 error summary and stickiness
    @(negedge clk); rx_overrun_i = 1; @(negedge clk); rx_overrun_i = 0;
    rd(3'd5, 8'hE2, "R7 overrun"); rd(3'd5, 8'h60, "R8 overrun cleared");
    @(negedge clk); rx_parity_err_i = 1; @(negedge clk); rx_parity_err_i = 0;
    rd(3'd5, 8'hE4, "R7 parity"); rd(3'd5, 8'h60, "R8 parity cleared");
    @(negedge clk); rx_frame_err_i = 1; @(negedge clk); rx_frame_err_i = 0;
    idle(5);
    rd(3'd5, 8'hE8, "R8 frame held"); rd(3'd5, 8'h60, "R8 frame cleared");
    @(negedge clk); rx_break_i = 1; @(negedge clk); rx_break_i = 0;
    rd(3'd5, 8'hF0, "R7 break"); rd(3'd5, 8'h60, "R8 break cleared");
    rx_overrun_i = 1;
    rd(3'd5, 8'hE2, "R8 held active 1");
    rd(3'd5, 8'hE2, "R8 held active 2");
    rx_overrun_i = 0;
    rd(3'd5, 8'hE2, "R8 still sticky");
    rd(3'd5, 8'h60, "R8 final clear");

    // R9 FIFO control pulses
    wr(3'd2, 8'h06);
    check("R9 both clr", {rx_fifo_clr_o, tx_fifo_clr_o}, 2'b11);
    idle(1);
    check("R9 clr single", {rx_fifo_clr_o, tx_fifo_clr_o}, 2'b00);
    wr(3'd2, 8'h02);
    check("R9 rx clr only", {rx_fifo_clr_o, tx_fifo_clr_o}, 2'b10);
    wr(3'd2, 8'h04);
    check("R9 tx clr only", {rx_fifo_clr_o, tx_fifo_clr_o}, 2'b01);
    rd(3'd2, 8'hC1, "R9 not stored");

    // R10 interrupt priority
    wr(3'd1, 8'h01); rx_ready_i = 1;
    rd(3'd2, 8'hC4, "R10 rx data");
    check("R10 irq", irq_o, 1);
    wr(3'd1, 8'h02); rx_ready_i = 0;
    rd(3'd2, 8'hC2, "R10 thr empty");
    wr(3'd1, 8'h03); rx_ready_i = 1;
    rd(3'd2, 8'hC4, "R10 rx over thr");
    wr(3'd1, 8'h07);
    @(negedge clk); rx_parity_err_i = 1; @(negedge clk); rx_parity_err_i = 0;
    rd(3'd2, 8'hC6, "R10 line first");
    rd(3'd2, 8'hC6, "R10 iid read keeps flag");
    rd(3'd5, 8'hE5, "R10 lstat clears");
    rd(3'd2, 8'hC4, "R10 falls back to rx");
    rx_ready_i = 0;
    wr(3'd1, 8'h08); msr_i = 8'h01;
    rd(3'd2, 8'hC0, "R10 modem");
    wr(3'd1, 8'h00);
    rd(3'd2, 8'hC1, "R10 none");
    check("R10 irq low", irq_o, 0);

    // R11 modem registers
    rd(3'd6, 8'h01, "R11 mstat");
    msr_i = 8'hB0;
    rd(3'd6, 8'hB0, "R11 mstat pass");
    msr_i = 8'h00;
    wr(3'd4, 8'hFF);
    rd(3'd4, 8'h1F, "R11 mctl width");
    check("R11 mcr_o", mcr_o, 5'h1F);

    // R12 spare offset
    wr(3'd7, 8'h55);
    rd(3'd7, 8'h00, "R12 spare read");
    rd(3'd3, 8'h03, "R12 lctl unchanged");
    rd(3'd4, 8'h1F, "R12 mctl unchanged");

    idle(2);
    if (sb.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
    end
    summary();
  end
endmodule